// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the register-level control unit of an I2C master. Software programs a target address with a direction bit, a data byte, a bit-timing period and an interrupt mask through a small word-indexed register port. It then writes a command word whose three low bits ask for three steps: take the bus, move one byte, and release the bus. The unit carries out the requested steps in that fixed order. Each step is a request/acknowledge handshake with an external bit engine, which produces the SCL/SDA waveforms. The unit then updates its status flags.

The unit keeps track of whether it owns the bus. When a byte is requested while the bus is not owned, the unit does not stall. It raises an error flag and drops the byte. An arbitration failure while taking the bus sets an arbitration-lost flag. Each completed byte sets a raw interrupt bit. That bit is masked onto a single interrupt line and is cleared by a write.

Register indices on `reg_addr`: 0 address, 1 command (write) / status (read), 2 data, 3 timer period, 4 interrupt mask, 5 raw interrupt, 6 masked interrupt (read) / interrupt clear (write), 7 configuration.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, the status register reads 0x20 (idle only). The data, period, address, mask, raw and configuration registers read 0, and `irq` is low.
- R2: The address register holds 8 bits. Bits 7:1 appear on `eng_addr` and bit 0 on `eng_read` (1 = read). The data and period registers are 8-bit read/write, and the period register drives `eng_period`.
- R3: A command write does nothing while configuration bit 4 (master enable) is clear: no engine request is made and the status is unchanged.
- R4: Command bit 1 issues an engine start (op 0) only when bus-busy (status 0x40) is clear. A start acknowledged with `eng_lost` low sets 0x40 and clears arbitration-lost (0x10). A start acknowledged with `eng_lost` high sets 0x10 and leaves 0x40 clear.
- R5: When command bit 0 is set and the bus is not owned, error (0x02) is set and no byte request (op 1) is made. When the bus is owned, error is cleared and the byte proceeds.
- R6: A byte step sends the data register on `eng_tx`. With direction read, it loads `eng_rx` into the data register. `eng_nack` on a start sets address-nack (0x04), and on a byte sets data-nack (0x08). Each flag is replaced at the next step of its kind.
- R7: Each completed byte sets raw interrupt bit 0. The masked register reads raw AND mask, and `irq` is high exactly when it is nonzero. Writing 1 to bit 0 of index 6 clears the raw bit.
- R8: Command bit 2 issues an engine stop (op 2) when the bus is owned, and its acknowledge clears 0x40. The steps of one command run in the order start, byte, stop.
- R9: While a handshake is outstanding, status reads busy (0x01) with idle (0x20) clear. During that time, writes to the command, address and data registers are ignored.
- R10: `eng_req` stays high with `eng_op` stable until `eng_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| eng_req | output | 1 | Handshake request to the bit engine |
| eng_op | output | 2 | Step: 0 start, 1 byte, 2 stop |
| eng_addr | output | 7 | Target address for a start |
| eng_read | output | 1 | Transfer direction, 1 = read |
| eng_tx | output | 8 | Byte to send |
| eng_period | output | 8 | Bit-timing period |
| eng_ack | input | 1 | Step finished (one-cycle pulse) |
| eng_rx | input | 8 | Received byte, valid with `eng_ack` |
| eng_nack | input | 1 | Target did not acknowledge, valid with `eng_ack` |
| eng_lost | input | 1 | Arbitration lost on a start, valid with `eng_ack` |
| irq | output | 1 | Transfer-done interrupt |

## Verification
The bench runs several sequences: a byte requested before any start, a start that loses arbitration followed by a byte in the same command, and a start with the bus already owned. A design that checked ownership too late would request a byte the engine model never expects; one that stalled instead of flagging would hang with busy set. Start and data nacks are placed on separate steps so that mixing up the two flags shows in the status value. During a slow stop, the bench writes the data and command registers. A design that did not block them would corrupt the data byte or issue an extra start. Disabled-master commands and the mask/clear path are also checked at the ports.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] RG_ADDR   = 3'd0;
  localparam logic [REG_AW-1:0] RG_CMD    = 3'd1;
  localparam logic [REG_AW-1:0] RG_DATA   = 3'd2;
  localparam logic [REG_AW-1:0] RG_PERIOD = 3'd3;
  localparam logic [REG_AW-1:0] RG_MASK   = 3'd4;
  localparam logic [REG_AW-1:0] RG_RAW    = 3'd5;
  localparam logic [REG_AW-1:0] RG_MIS    = 3'd6;
  localparam logic [REG_AW-1:0] RG_CFG    = 3'd7;

  localparam int unsigned ST_BUSY   = 0;
  localparam int unsigned ST_ERR    = 1;
  localparam int unsigned ST_ANACK  = 2;
  localparam int unsigned ST_DNACK  = 3;
  localparam int unsigned ST_ARB    = 4;
  localparam int unsigned ST_IDLE   = 5;
  localparam int unsigned ST_BUSBSY = 6;

  localparam int unsigned CFG_EN_BIT = 4;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } eng_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_START,
    SQ_BYTE,
    SQ_STOP
  } sq_state_e;

endpackage

// File: rtl/i2cs_rst_sync.sv
module i2cs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
  import i2cs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  input  logic              cap_en,
  input  logic [DW-1:0]     cap_data,
  output logic [DW-1:0]     addr_q,
  output logic [DW-1:0]     data_q,
  output logic [DW-1:0]     period_q,
  output logic              cfg_en
);
  logic          addr_we, data_we, period_we, cfg_we;
  logic [DW-1:0] data_d;

  always_comb begin
    addr_we   = wr && (idx == RG_ADDR) && !busy;
    period_we = wr && (idx == RG_PERIOD);
    cfg_we    = wr && (idx == RG_CFG);
    data_we   = cap_en || (wr && (idx == RG_DATA) && !busy);
    data_d    = cap_en ? cap_data : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      data_q   <= '0;
      period_q <= '0;
      cfg_en   <= 1'b0;
    end else begin
      if (addr_we)   addr_q   <= wdata;
      if (data_we)   data_q   <= data_d;
      if (period_we) period_q <= wdata;
      if (cfg_we)    cfg_en   <= wdata[CFG_EN_BIT];
    end
  end
endmodule

// File: rtl/i2cs_irq.sv
module i2cs_irq #(
  parameter int unsigned IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] set_vec,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [IW-1:0] wbits,
  output logic [IW-1:0] mask_q,
  output logic [IW-1:0] raw_q,
  output logic [IW-1:0] masked,
  output logic          irq
);
  logic [IW-1:0] raw_d;
  logic          raw_en;

  always_comb begin
    raw_en = clr_we || (|set_vec);
    raw_d  = (raw_q & ~(clr_we ? wbits : '0)) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      if (raw_en)  raw_q  <= raw_d;
      if (mask_we) mask_q <= wbits;
    end
  end

  assign masked = raw_q & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [2:0]    cmd,
  input  logic          enable,
  input  logic          dir_read,
  input  logic          eng_ack,
  input  logic          eng_nack,
  input  logic          eng_lost,
  input  logic [DW-1:0] eng_rx,
  output logic          eng_req,
  output logic [1:0]    eng_op,
  output logic [7:0]    status,
  output logic          busy,
  output logic          cap_en,
  output logic [DW-1:0] cap_data,
  output logic          done
);
  sq_state_e state_q, state_d;
  logic run_q, run_d, stop_q, stop_d, own_q, own_d;
  logic err_q, err_d, arb_q, arb_d, an_q, an_d, dn_q, dn_d;
  logic cmd_fire, upd;

  function automatic sq_state_e pick(input logic own, input logic run, input logic stp);
    if (run)             return own ? SQ_BYTE : SQ_IDLE;
    else if (stp && own) return SQ_STOP;
    else                 return SQ_IDLE;
  endfunction

  assign cmd_fire = cmd_wr && enable && (state_q == SQ_IDLE);
  assign upd      = cmd_fire || ((state_q != SQ_IDLE) && eng_ack);
  assign cap_data = eng_rx;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    stop_d  = stop_q;
    own_d   = own_q;
    err_d   = err_q;
    arb_d   = arb_q;
    an_d    = an_q;
    dn_d    = dn_q;
    cap_en  = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (cmd_fire) begin
          run_d  = cmd[0];
          stop_d = cmd[2];
          if (cmd[1] && !own_q) begin
            state_d = SQ_START;
          end else begin
            state_d = pick(own_q, cmd[0], cmd[2]);
            if (cmd[0]) err_d = !own_q;
          end
        end
      end
      SQ_START: begin
        if (eng_ack) begin
          own_d   = !eng_lost;
          arb_d   = eng_lost;
          an_d    = eng_nack && !eng_lost;
          state_d = pick(!eng_lost, run_q, stop_q);
          if (run_q) err_d = eng_lost;
        end
      end
      SQ_BYTE: begin
        if (eng_ack) begin
          dn_d    = eng_nack;
          cap_en  = dir_read;
          done    = 1'b1;
          state_d = stop_q ? SQ_STOP : SQ_IDLE;
        end
      end
      SQ_STOP: begin
        if (eng_ack) begin
          own_d   = 1'b0;
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      run_q   <= 1'b0;
      stop_q  <= 1'b0;
      own_q   <= 1'b0;
      err_q   <= 1'b0;
      arb_q   <= 1'b0;
      an_q    <= 1'b0;
      dn_q    <= 1'b0;
    end else if (upd) begin
      state_q <= state_d;
      run_q   <= run_d;
      stop_q  <= stop_d;
      own_q   <= own_d;
      err_q   <= err_d;
      arb_q   <= arb_d;
      an_q    <= an_d;
      dn_q    <= dn_d;
    end
  end

  always_comb begin
    unique case (state_q)
      SQ_START: eng_op = OP_START;
      SQ_BYTE:  eng_op = OP_BYTE;
      SQ_STOP:  eng_op = OP_STOP;
      default:  eng_op = OP_START;
    endcase
  end

  assign eng_req = (state_q != SQ_IDLE);
  assign busy    = eng_req;

  always_comb begin
    status            = '0;
    status[ST_BUSY]   = busy;
    status[ST_ERR]    = err_q;
    status[ST_ANACK]  = an_q;
    status[ST_DNACK]  = dn_q;
    status[ST_ARB]    = arb_q;
    status[ST_IDLE]   = !busy;
    status[ST_BUSBSY] = own_q;
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cs_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [DW-2:0]     eng_addr,
  output logic              eng_read,
  output logic [DW-1:0]     eng_tx,
  output logic [DW-1:0]     eng_period,
  input  logic              eng_ack,
  input  logic [DW-1:0]     eng_rx,
  input  logic              eng_nack,
  input  logic              eng_lost,
  output logic              irq
);
  localparam int unsigned PADS = DW - 8;

  logic          rst_q;
  logic [DW-1:0] addr_q, data_q, period_q, cap_data;
  logic          cfg_en, busy, cap_en, done;
  logic [7:0]    status;
  logic [IW-1:0] mask_q, raw_q, masked, set_vec;
  logic          cmd_wr, mask_we, clr_we;

  i2cs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  assign cmd_wr  = reg_wr && (reg_addr == RG_CMD);
  assign mask_we = reg_wr && (reg_addr == RG_MASK);
  assign clr_we  = reg_wr && (reg_addr == RG_MIS);
  assign set_vec = IW'(done);

  i2cs_regfile #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr(reg_wr), .idx(reg_addr), .wdata(reg_wdata),
    .busy(busy), .cap_en(cap_en), .cap_data(cap_data),
    .addr_q(addr_q), .data_q(data_q), .period_q(period_q), .cfg_en(cfg_en)
  );

  i2cs_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_q), .cmd_wr(cmd_wr), .cmd(reg_wdata[2:0]),
    .enable(cfg_en), .dir_read(addr_q[0]),
    .eng_ack(eng_ack), .eng_nack(eng_nack), .eng_lost(eng_lost), .eng_rx(eng_rx),
    .eng_req(eng_req), .eng_op(eng_op), .status(status), .busy(busy),
    .cap_en(cap_en), .cap_data(cap_data), .done(done)
  );

  i2cs_irq #(.IW(IW)) u_irq (
    .clk(clk), .rst_n(rst_q), .set_vec(set_vec), .mask_we(mask_we),
    .clr_we(clr_we), .wbits(reg_wdata[IW-1:0]),
    .mask_q(mask_q), .raw_q(raw_q), .masked(masked), .irq(irq)
  );

  assign eng_addr   = addr_q[DW-1:1];
  assign eng_read   = addr_q[0];
  assign eng_tx     = data_q;
  assign eng_period = period_q;

  logic [DW-1:0] status_w, cfg_w;

  generate
    if (PADS > 0) begin : g_pad
      assign status_w = {{PADS{1'b0}}, status};
    end else begin : g_nopad
      assign status_w = status;
    end
  endgenerate

  always_comb begin
    cfg_w             = '0;
    cfg_w[CFG_EN_BIT] = cfg_en;
  end

  always_comb begin
    unique case (reg_addr)
      RG_ADDR:   reg_rdata = addr_q;
      RG_CMD:    reg_rdata = status_w;
      RG_DATA:   reg_rdata = data_q;
      RG_PERIOD: reg_rdata = period_q;
      RG_MASK:   reg_rdata = DW'(mask_q);
      RG_RAW:    reg_rdata = DW'(raw_q);
      RG_MIS:    reg_rdata = DW'(masked);
      default:   reg_rdata = cfg_w;
    endcase
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
  import i2cs_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 1
) (
  input logic              clk,
  input logic              rst_q,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic              eng_req,
  input logic [1:0]        eng_op,
  input logic              eng_ack,
  input logic              eng_lost,
  input logic [7:0]        status,
  input logic [IW-1:0]     raw_q,
  input logic              cfg_en,
  input logic [DW-1:0]     data_q
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op)));

  assert_start_ok_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (eng_req && eng_ack && eng_op == OP_START && !eng_lost)
      |=> (status[ST_BUSBSY] && !status[ST_ARB]));

  assert_start_lost_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (eng_req && eng_ack && eng_op == OP_START && eng_lost)
      |=> (status[ST_ARB] && !status[ST_BUSBSY]));

  assert_done_raw_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (eng_req && eng_ack && eng_op == OP_BYTE) |=> raw_q[0]);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (eng_req && eng_ack && eng_op == OP_STOP) |=> !status[ST_BUSBSY]);

  assert_data_locked_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (eng_req && !eng_ack && reg_wr && reg_addr == RG_DATA) |=> $stable(data_q));

  assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (!eng_req && !cfg_en && reg_wr && reg_addr == RG_CMD) |=> !eng_req);
endmodule

bind i2c_cmd_seq i2cs_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_q(rst_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .eng_req(eng_req), .eng_op(eng_op), .eng_ack(eng_ack), .eng_lost(eng_lost),
  .status(status), .raw_q(raw_q), .cfg_en(cfg_en), .data_q(data_q)
);

// File: tb/tb_i2c_cmd_seq.sv
`timescale 1ns/1ps
module tb_i2c_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       eng_req;
  logic [1:0] eng_op;
  logic [6:0] eng_addr;
  logic       eng_read;
  logic [7:0] eng_tx, eng_period;
  logic       eng_ack = 1'b0;
  logic [7:0] eng_rx = 8'd0;
  logic       eng_nack = 1'b0;
  logic       eng_lost = 1'b0;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // scoreboard: {op[1:0], rd, addr[6:0], tx[7:0]}
  logic [17:0] exp_q[$];
  string       tag_q[$];

  int         lat = 3;
  logic       resp_lost = 1'b0;
  logic       resp_nack = 1'b0;
  logic [7:0] resp_rx = 8'd0;

  always #2 clk = ~clk;

  i2c_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_req(eng_req),
    .eng_op(eng_op), .eng_addr(eng_addr), .eng_read(eng_read), .eng_tx(eng_tx),
    .eng_period(eng_period), .eng_ack(eng_ack), .eng_rx(eng_rx),
    .eng_nack(eng_nack), .eng_lost(eng_lost), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic rd, input logic [6:0] a,
                      input logic [7:0] tx, input string tag);
    exp_q.push_back({op, rd, a, tx});
    tag_q.push_back(tag);
  endtask

  // monitor / bit engine model
  int         cnt = 0;
  logic [1:0] seen_op = 2'd0;
  always @(negedge clk) begin
    if (eng_ack) begin
      eng_ack = 1'b0;
      cnt = 0;
    end else if (eng_req) begin
      if (cnt == 0) seen_op = eng_op;
      cnt++;
      if (cnt >= lat) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 R5 R9 unexpected engine step", {30'd0, eng_op}, 32'hff);
        end else begin
          logic [17:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(eng_op == e[17:16], {t, " step op"}, {30'd0, eng_op}, {30'd0, e[17:16]});
          chk(seen_op == eng_op, "R10 op held until ack", {30'd0, eng_op}, {30'd0, seen_op});
          if (e[17:16] == 2'd0)
            chk(eng_addr == e[14:8], {t, " start addr R2"}, {25'd0, eng_addr}, {25'd0, e[14:8]});
          if (e[17:16] != 2'd2)
            chk(eng_read == e[15], {t, " dir R2"}, {31'd0, eng_read}, {31'd0, e[15]});
          if (e[17:16] == 2'd1 && !e[15])
            chk(eng_tx == e[7:0], {t, " tx byte R6"}, {24'd0, eng_tx}, {24'd0, e[7:0]});
        end
        eng_lost = (eng_op == 2'd0) ? resp_lost : 1'b0;
        eng_nack = resp_nack;
        eng_rx   = resp_rx;
        eng_ack  = 1'b1;
        cnt = 0;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      reg_addr = 3'd1;
      #1;
      if (!reg_rdata[0]) break;
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    rd(3'd1, 8'h20, "R1 status reset");
    rd(3'd2, 8'h00, "R1 data reset");
    rd(3'd3, 8'h00, "R1 period reset");
    rd(3'd5, 8'h00, "R1 raw reset");
    rd(3'd7, 8'h00, "R1 cfg reset");
    chk(irq == 1'b0, "R1 irq reset", {31'd0, irq}, 0);

    wr(3'd0, 8'hA5); rd(3'd0, 8'hA5, "R2 address readback");
    wr(3'd3, 8'h3C); rd(3'd3, 8'h3C, "R2 period readback");
    chk(eng_period == 8'h3C, "R2 period output", {24'd0, eng_period}, 32'h3C);
    wr(3'd2, 8'h5A); rd(3'd2, 8'h5A, "R2 data readback");

    // disabled master: no step expected
    wr(3'd1, 8'h07);
    repeat (10) @(negedge clk);
    rd(3'd1, 8'h20, "R3 disabled command ignored");

    wr(3'd7, 8'h10); rd(3'd7, 8'h10, "R3 enable readback");

    // byte without owning the bus
    wr(3'd1, 8'h01);
    repeat (8) @(negedge clk);
    rd(3'd1, 8'h22, "R5 byte while not owned sets error");

    // start + write byte
    wr(3'd0, 8'hA4);
    push(2'd0, 1'b0, 7'h52, 8'h00, "R4");
    push(2'd1, 1'b0, 7'h00, 8'h5A, "R6");
    wr(3'd1, 8'h03);
    wait_idle();
    rd(3'd1, 8'h60, "R4 R5 owned, error cleared");
    rd(3'd5, 8'h01, "R7 raw set on done");
    rd(3'd6, 8'h00, "R7 masked zero with mask off");
    chk(irq == 1'b0, "R7 irq low when masked", {31'd0, irq}, 0);
    wr(3'd4, 8'h01);
    rd(3'd6, 8'h01, "R7 masked with mask on");
    chk(irq == 1'b1, "R7 irq high", {31'd0, irq}, 1);
    wr(3'd6, 8'h01);
    rd(3'd5, 8'h00, "R7 raw cleared");
    chk(irq == 1'b0, "R7 irq low after clear", {31'd0, irq}, 0);

    // byte + stop with data nack, bus already owned
    resp_nack = 1'b1;
    wr(3'd2, 8'h33);
    push(2'd1, 1'b0, 7'h00, 8'h33, "R6");
    push(2'd2, 1'b0, 7'h00, 8'h00, "R8");
    wr(3'd1, 8'h05);
    wait_idle();
    rd(3'd1, 8'h28, "R8 R6 released with data nack");
    wr(3'd6, 8'h01);

    // full read: start, byte, stop
    resp_nack = 1'b0; resp_rx = 8'hC3;
    wr(3'd0, 8'hA5);
    push(2'd0, 1'b1, 7'h52, 8'h00, "R8");
    push(2'd1, 1'b1, 7'h00, 8'h00, "R8");
    push(2'd2, 1'b0, 7'h00, 8'h00, "R8");
    wr(3'd1, 8'h07);
    wait_idle();
    rd(3'd1, 8'h20, "R8 read sequence status");
    rd(3'd2, 8'hC3, "R6 received byte captured");
    wr(3'd6, 8'h01);

    // arbitration lost on start, byte dropped
    resp_lost = 1'b1;
    push(2'd0, 1'b1, 7'h52, 8'h00, "R4");
    wr(3'd1, 8'h03);
    wait_idle();
    rd(3'd1, 8'h32, "R4 R5 arbitration lost");
    rd(3'd5, 8'h00, "R5 no byte after lost start");

    // start with address nack
    resp_lost = 1'b0; resp_nack = 1'b1;
    push(2'd0, 1'b1, 7'h52, 8'h00, "R4");
    wr(3'd1, 8'h02);
    wait_idle();
    rd(3'd1, 8'h66, "R4 R6 address nack, owned");

    // slow stop, writes during busy
    resp_nack = 1'b0; lat = 8;
    push(2'd2, 1'b0, 7'h00, 8'h00, "R8");
    wr(3'd1, 8'h04);
    rd(3'd1, 8'h47, "R9 busy set, idle clear");
    wr(3'd2, 8'h77);
    wr(3'd1, 8'h02);
    wait_idle();
    lat = 3;
    rd(3'd1, 8'h26, "R9 R8 stop done");
    rd(3'd2, 8'hC3, "R9 data write ignored while busy");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all expected steps issued", exp_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R9 watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule